// File: doc/BRIEF.md
# Arithmetic Unit with Held Comparison Flags

This block is the data path at the heart of a small accumulator machine. An 8-bit combinational arithmetic unit takes the accumulator as its first operand and a second operand that an upstream selector has already picked, either an immediate constant or a data-memory word. A 2-bit operation code chooses one of four functions: pass the second operand through, subtract, multiply, or compare. The compare function yields two flags. The magnitude flag is set when the first operand is at least the second, unsigned. The equality flag is set when the two operands match.

The next instruction needs the two flags, for example a conditional jump taken when the first operand was smaller. During that instruction the live arithmetic outputs follow new operands, so their flag values are meaningless. For this reason the flags are captured in a two-bit register on the clock edge that ends the compare instruction. The register holds its value until another compare is captured. Instruction decode drives a capture enable. The register loads only when that enable is high and the compare code is present together. The interface has no flow control. Operands and operation code are plain control-rate signals, valid every cycle.

Top module: `alu_flagged`

## Requirements
- R1: With operation code 2'b00, `alu_result` equals `operand_b`.
- R2: With operation code 2'b01, `alu_result` equals `operand_a` minus `operand_b`, kept to its low 8 bits (wraps on borrow).
- R3: With operation code 2'b10, `alu_result` equals the low 8 bits of the unsigned product `operand_a` times `operand_b`.
- R4: With operation code 2'b11 (compare), `alu_result` is 0.
- R5: For every operation code, `live_ge` is 1 exactly when `operand_a` >= `operand_b` (unsigned), and `live_eq` is 1 exactly when they are equal.
- R6: On a rising clock edge with operation code 2'b11 and `flag_capture_en` high, `flag_ge_q` and `flag_eq_q` take the comparison of the operands present before that edge.
- R7: On any other rising edge the stored flags keep their value, whatever the operands, the code or the live flags do.
- R8: An active-low `rst_n` clears both stored flags to 0 asynchronously.
- R9: The stored equality flag is never 1 while the stored magnitude flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 2 | Function select: 00 pass B, 01 subtract, 10 multiply, 11 compare |
| operand_a | input | 8 | First operand (accumulator) |
| operand_b | input | 8 | Second operand (immediate or memory) |
| flag_capture_en | input | 1 | Allows a compare to be stored in the flag register |
| alu_result | output | 8 | Combinational result |
| live_ge | output | 1 | Unregistered A >= B |
| live_eq | output | 1 | Unregistered A == B |
| flag_ge_q | output | 1 | Stored A >= B from the last captured compare |
| flag_eq_q | output | 1 | Stored A == B from the last captured compare |

## Verification
The assertions check on every clocked cycle the four result functions, the live flags, the load of the flag register on a gated compare, its hold on all other edges, and the consistency of the two stored flags. Whether a flag captured several cycles back is still correct after long runs of unrelated subtract and multiply traffic is shown only by the bench, which keeps its own record of the last captured compare. The same holds for clearing the flags asynchronously by a reset in the middle of a run and for wrap-around corners such as 0 minus 255 and 16 times 16.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;
  typedef enum logic [1:0] {
    OP_PASS_B = 2'b00,
    OP_SUB    = 2'b01,
    OP_MUL    = 2'b10,
    OP_CMP    = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic ge;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0]                  a,
  input  logic [W-1:0]                  b,
  output alu_flagged_pkg::cmp_flags_t   flags
);
  always_comb begin
    flags.ge = (a >= b);
    flags.eq = (a == b);
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8
) (
  input  alu_flagged_pkg::alu_op_e op,
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  output logic [W-1:0]             y
);
  import alu_flagged_pkg::*;

  logic [W-1:0] diff;
  logic [W-1:0] prod;

  assign diff = a - b;
  assign prod = a * b;

  always_comb begin
    unique case (op)
      OP_PASS_B: y = b;
      OP_SUB:    y = diff;
      OP_MUL:    y = prod;
      OP_CMP:    y = '0;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  alu_flagged_pkg::cmp_flags_t  d,
  output alu_flagged_pkg::cmp_flags_t  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_code,
  input  logic [W-1:0] operand_a,
  input  logic [W-1:0] operand_b,
  input  logic         flag_capture_en,
  output logic [W-1:0] alu_result,
  output logic         live_ge,
  output logic         live_eq,
  output logic         flag_ge_q,
  output logic         flag_eq_q
);
  import alu_flagged_pkg::*;

  alu_op_e    op;
  cmp_flags_t live_flags;
  cmp_flags_t held_flags;
  logic       capture;

  assign op      = alu_op_e'(op_code);
  assign capture = flag_capture_en && (op == OP_CMP);

  alu_arith #(.W(W)) u_arith (
    .op (op),
    .a  (operand_a),
    .b  (operand_b),
    .y  (alu_result)
  );

  alu_compare #(.W(W)) u_cmp (
    .a     (operand_a),
    .b     (operand_b),
    .flags (live_flags)
  );

  alu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture),
    .d     (live_flags),
    .q     (held_flags)
  );

  assign live_ge   = live_flags.ge;
  assign live_eq   = live_flags.eq;
  assign flag_ge_q = held_flags.ge;
  assign flag_eq_q = held_flags.eq;
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   op_code,
  input logic [W-1:0] operand_a,
  input logic [W-1:0] operand_b,
  input logic         flag_capture_en,
  input logic [W-1:0] alu_result,
  input logic         live_ge,
  input logic         live_eq,
  input logic         flag_ge_q,
  input logic         flag_eq_q
);
  logic [W-1:0] exp_diff;
  logic [W-1:0] exp_prod;
  assign exp_diff = operand_a - operand_b;
  assign exp_prod = operand_a * operand_b;

  AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b00) |-> (alu_result == operand_b));  // R1
  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b01) |-> (alu_result == exp_diff));  // R2
  AST_MUL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b10) |-> (alu_result == exp_prod));  // R3
  AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b11) |-> (alu_result == '0));  // R4
  AST_LIVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_ge == (operand_a >= operand_b)) && (live_eq == (operand_a == operand_b)));  // R5
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b11 && flag_capture_en) |=>
      (flag_ge_q == $past(operand_a >= operand_b)) && (flag_eq_q == $past(operand_a == operand_b)));  // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_code == 2'b11 && flag_capture_en) |=> ($stable(flag_ge_q) && $stable(flag_eq_q)));  // R7
  AST_EQ_NEEDS_GE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_eq_q |-> flag_ge_q);  // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!flag_ge_q && !flag_eq_q);  // R8
    end
  end
endmodule

bind alu_flagged alu_flagged_chk #(.W(W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_code         (op_code),
  .operand_a       (operand_a),
  .operand_b       (operand_b),
  .flag_capture_en (flag_capture_en),
  .alu_result      (alu_result),
  .live_ge         (live_ge),
  .live_eq         (live_eq),
  .flag_ge_q       (flag_ge_q),
  .flag_eq_q       (flag_eq_q)
);

// File: tb/alu_flagged_tb_top.sv
module alu_flagged_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_code;
  logic [7:0] operand_a;
  logic [7:0] operand_b;
  logic       flag_capture_en;
  logic [7:0] alu_result;
  logic       live_ge, live_eq, flag_ge_q, flag_eq_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic m_ge = 1'b0;
  logic m_eq = 1'b0;

  always #2 clk = ~clk;

  alu_flagged dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code),
    .operand_a(operand_a), .operand_b(operand_b),
    .flag_capture_en(flag_capture_en), .alu_result(alu_result),
    .live_ge(live_ge), .live_eq(live_eq),
    .flag_ge_q(flag_ge_q), .flag_eq_q(flag_eq_q)
  );

  function automatic logic [7:0] exp_result(logic [1:0] op, logic [7:0] a, logic [7:0] b);
    logic [15:0] p;
    case (op)
      2'b00: return b;
      2'b01: return 8'(a - b);
      2'b10: begin p = a * b; return p[7:0]; end
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] op, logic [7:0] a, logic [7:0] b, logic en);
    string rtag;
    @(negedge clk);
    op_code = op; operand_a = a; operand_b = b; flag_capture_en = en;
    #1;
    case (op)
      2'b00: rtag = "R1";
      2'b01: rtag = "R2";
      2'b10: rtag = "R3";
      default: rtag = "R4";
    endcase
    chk(rtag, {8'd0, alu_result}, {8'd0, exp_result(op, a, b)});
    chk("R5", {14'd0, live_ge, live_eq}, {14'd0, a >= b, a == b});
    if (op == 2'b11 && en) begin
      m_ge = (a >= b);
      m_eq = (a == b);
    end
    @(posedge clk);
    #1;
    // R6 on a capture, R7 otherwise; R9 follows from the model
    chk((op == 2'b11 && en) ? "R6" : "R7",
        {14'd0, flag_ge_q, flag_eq_q}, {14'd0, m_ge, m_eq});
    chk("R9", {15'd0, flag_eq_q & ~flag_ge_q}, 16'd0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; op_code = 2'b00; operand_a = 8'd0; operand_b = 8'd0; flag_capture_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", {14'd0, flag_ge_q, flag_eq_q}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    step(2'b11, 8'd2, 8'd2, 1'b1);     // equal: both flags set
    step(2'b01, 8'd0, 8'd255, 1'b1);   // borrow wrap, no capture on non-compare
    step(2'b10, 8'd16, 8'd16, 1'b1);   // product truncates to 0
    step(2'b11, 8'd1, 8'd2, 1'b0);     // compare without enable: hold
    step(2'b11, 8'd1, 8'd2, 1'b1);     // less: both clear
    step(2'b00, 8'd9, 8'd200, 1'b0);
    step(2'b11, 8'd255, 8'd0, 1'b1);   // greater: ge only
    step(2'b10, 8'd12, 8'd2, 1'b0);
    step(2'b11, 8'd0, 8'd0, 1'b1);

    // asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", {14'd0, flag_ge_q, flag_eq_q}, 16'd0);
    m_ge = 1'b0; m_eq = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // random traffic, compares made rarer so holds last several cycles
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [7:0] a, b;
      logic en;
      op = 2'($urandom_range(0, 3));
      a  = 8'($urandom);
      b  = ($urandom_range(0, 7) == 0) ? a : 8'($urandom);
      en = ($urandom_range(0, 2) == 0);
      step(op, a, b, en);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule